// File: doc/BRIEF.md
# Four-Bank SDRAM Command Timing Guard

This block sits beside an SDRAM command scheduler. Each cycle it judges whether a proposed activate, read, write or precharge may go to the addressed bank. It keeps its own record of what each of four banks is doing: whether a row is open, and how many clocks remain before each timing minimum is met. The scheduler presents a bank address and reads back one legality flag per command type. When it actually sends a command, it pulses `issue_i` together with that command's code.

All timing limits are parameters counted in clocks. A limit given in nanoseconds is divided by the clock period and rounded up before it is passed in. The guard also watches how long each row has been open. It raises a per-bank request to close the row a configurable number of clocks before the maximum open time runs out. The data path is not part of this block.

Top module: `sdram_timing_guard`

## Requirements
- R1: After reset every bank is closed. For any bank, `act_ok_o` is 1 and `rd_ok_o`, `wr_ok_o`, `pre_ok_o` and all `force_pre_o` bits are 0. Command codes on `cmd_i` are 0 = activate, 1 = read, 2 = write, 3 = precharge.
- R2: Read, write or precharge to a closed bank is illegal. Activate to an open bank is illegal.
- R3: Read and write to a bank become legal T_RCD clocks after that bank's accepted activate, and not sooner.
- R4: An activate to any bank is illegal until T_RRD clocks after the most recent accepted activate to any bank.
- R5: Precharge to a bank is illegal until T_RAS clocks after that bank's accepted activate.
- R6: A closed bank may not be activated until T_RP clocks after its accepted precharge.
- R7: A bank may not be activated again until T_RC clocks after its previous accepted activate.
- R8: Precharge to a bank is illegal until T_WR clocks after an accepted write to that bank.
- R9: Read and write to any bank are illegal until T_CDL clocks after an accepted write to any bank.
- R10: `force_pre_o[b]` is 1 while bank b is open and at least T_RAS_MAX - FORCE_MARGIN clocks have passed since its activate. It drops the cycle after the bank is precharged.
- R11: A command presented with `issue_i` high whose flag is 0, or any command with `issue_i` low, changes no state. Every later flag is then as if that cycle were idle.
- R12: The four flags refer to the bank on `bank_i` in the same cycle. They are combinational from the stored state, so changing `bank_i` changes them without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_i | input | 1 | The command on `cmd_i` is being sent this cycle |
| cmd_i | input | 2 | Command code: 0 activate, 1 read, 2 write, 3 precharge |
| bank_i | input | BANK_BITS | Addressed bank |
| act_ok_o | output | 1 | Activate to `bank_i` is legal now |
| rd_ok_o | output | 1 | Read to `bank_i` is legal now |
| wr_ok_o | output | 1 | Write to `bank_i` is legal now |
| pre_ok_o | output | 1 | Precharge to `bank_i` is legal now |
| force_pre_o | output | 2**BANK_BITS | Per-bank request to close the row before its open limit |

## Verification
On every cycle, the assertions check the relations that hold one clock after an accepted command. A just-activated bank cannot be activated again. A just-closed bank offers no column or precharge access. A write blocks the next-cycle precharge. Activate spacing blocks every bank on the next cycle. A bank is never ready both for activation and for column or precharge access. Precharge clears the close request. The exact clock at which each window opens, the shared column hold-off after writes, and the rise of the close request near the row-open limit are shown only by the bench. It compares every flag against a cycle-stamped model under directed sequences and seeded random traffic.

// File: rtl/sdtg_pkg.sv
package sdtg_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } sdtg_cmd_e;

endpackage

// File: rtl/sdtg_rst_sync.sv
module sdtg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync_o = sync_q[1];

endmodule

// File: rtl/sdtg_downcnt.sv
// Saturating down-counter: loads LOAD on load_i, then counts to zero.
module sdtg_downcnt #(
  parameter int unsigned LOAD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic zero_o
);

  localparam int unsigned W = (LOAD < 2) ? 1 : $clog2(LOAD + 1);
  localparam logic [W-1:0] LOAD_V = W'(LOAD);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = LOAD_V;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdtg_bank.sv
// Per-bank open/closed state with its timing windows and row-open limit.
module sdtg_bank #(
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_RC      = 10,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_WR      = 2,
  parameter int unsigned T_RAS_MAX = 5000,
  parameter int unsigned MARGIN    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go_i,
  input  logic wr_go_i,
  input  logic pre_go_i,
  output logic active_o,
  output logic act_rdy_o,
  output logic col_rdy_o,
  output logic pre_rdy_o,
  output logic force_pre_o
);

  localparam int unsigned OW = (T_RAS_MAX < 3) ? 1 : $clog2(T_RAS_MAX);
  localparam logic [OW-1:0] OPEN_LOAD = OW'(T_RAS_MAX - 1);
  localparam logic [OW-1:0] MARGIN_V  = OW'(MARGIN);

  logic rcd_zero;
  logic ras_zero;
  logic rc_zero;
  logic rp_zero;
  logic wr_zero;

  sdtg_downcnt #(.LOAD(T_RCD - 1)) u_rcd (
    .clk(clk), .rst_n(rst_n), .load_i(act_go_i), .zero_o(rcd_zero));
  sdtg_downcnt #(.LOAD(T_RAS - 1)) u_ras (
    .clk(clk), .rst_n(rst_n), .load_i(act_go_i), .zero_o(ras_zero));
  sdtg_downcnt #(.LOAD(T_RC - 1)) u_rc (
    .clk(clk), .rst_n(rst_n), .load_i(act_go_i), .zero_o(rc_zero));
  sdtg_downcnt #(.LOAD(T_RP - 1)) u_rp (
    .clk(clk), .rst_n(rst_n), .load_i(pre_go_i), .zero_o(rp_zero));
  sdtg_downcnt #(.LOAD(T_WR - 1)) u_wr (
    .clk(clk), .rst_n(rst_n), .load_i(wr_go_i), .zero_o(wr_zero));

  // open/closed state
  logic active_q;
  logic active_d;
  logic active_en;

  always_comb begin
    active_en = act_go_i || pre_go_i;
    active_d  = active_q;
    if (act_go_i) begin
      active_d = 1'b1;
    end else if (pre_go_i) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else if (active_en) begin
      active_q <= active_d;
    end
  end

  // remaining row-open budget
  logic [OW-1:0] open_q;
  logic [OW-1:0] open_d;
  logic          open_en;

  always_comb begin
    open_en = act_go_i || (active_q && (open_q != '0));
    open_d  = open_q;
    if (act_go_i) begin
      open_d = OPEN_LOAD;
    end else if (active_q && (open_q != '0)) begin
      open_d = open_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
    end else if (open_en) begin
      open_q <= open_d;
    end
  end

  assign active_o    = active_q;
  assign act_rdy_o   = !active_q && rc_zero && rp_zero;
  assign col_rdy_o   = active_q && rcd_zero;
  assign pre_rdy_o   = active_q && ras_zero && wr_zero;
  assign force_pre_o = active_q && (open_q <= MARGIN_V);

endmodule

// File: rtl/sdram_timing_guard.sv
module sdram_timing_guard
  import sdtg_pkg::*;
#(
  parameter int unsigned BANK_BITS    = 2,
  parameter int unsigned T_RCD        = 3,
  parameter int unsigned T_RRD        = 2,
  parameter int unsigned T_RAS        = 6,
  parameter int unsigned T_RC         = 10,
  parameter int unsigned T_RP         = 3,
  parameter int unsigned T_WR         = 2,
  parameter int unsigned T_CDL        = 1,
  parameter int unsigned T_RAS_MAX    = 5000,
  parameter int unsigned FORCE_MARGIN = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        issue_i,
  input  logic [1:0]                  cmd_i,
  input  logic [BANK_BITS-1:0]        bank_i,
  output logic                        act_ok_o,
  output logic                        rd_ok_o,
  output logic                        wr_ok_o,
  output logic                        pre_ok_o,
  output logic [(1<<BANK_BITS)-1:0]   force_pre_o
);

  localparam int unsigned NUM_BANKS = 1 << BANK_BITS;

  logic rst_n_int;

  sdtg_rst_sync u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  sdtg_cmd_e cmd;
  assign cmd = sdtg_cmd_e'(cmd_i);

  logic [NUM_BANKS-1:0] bank_active;
  logic [NUM_BANKS-1:0] bank_act_rdy;
  logic [NUM_BANKS-1:0] bank_col_rdy;
  logic [NUM_BANKS-1:0] bank_pre_rdy;
  logic [NUM_BANKS-1:0] bank_hit;

  logic rrd_zero;
  logic cdl_zero;
  logic act_go;
  logic wr_go;
  logic pre_go;

  // legality of each command type for the addressed bank
  always_comb begin
    act_ok_o = bank_act_rdy[bank_i] && rrd_zero;
    rd_ok_o  = bank_col_rdy[bank_i] && cdl_zero;
    wr_ok_o  = bank_col_rdy[bank_i] && cdl_zero;
    pre_ok_o = bank_pre_rdy[bank_i];
  end

  // accepted commands only
  always_comb begin
    act_go = issue_i && (cmd == CMD_ACT) && act_ok_o;
    wr_go  = issue_i && (cmd == CMD_WR)  && wr_ok_o;
    pre_go = issue_i && (cmd == CMD_PRE) && pre_ok_o;
  end

  sdtg_downcnt #(.LOAD(T_RRD - 1)) u_rrd (
    .clk(clk), .rst_n(rst_n_int), .load_i(act_go), .zero_o(rrd_zero));

  sdtg_downcnt #(.LOAD(T_CDL - 1)) u_cdl (
    .clk(clk), .rst_n(rst_n_int), .load_i(wr_go), .zero_o(cdl_zero));

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    assign bank_hit[gb] = (bank_i == BANK_BITS'(gb));

    sdtg_bank #(
      .T_RCD     (T_RCD),
      .T_RAS     (T_RAS),
      .T_RC      (T_RC),
      .T_RP      (T_RP),
      .T_WR      (T_WR),
      .T_RAS_MAX (T_RAS_MAX),
      .MARGIN    (FORCE_MARGIN)
    ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n_int),
      .act_go_i    (act_go && bank_hit[gb]),
      .wr_go_i     (wr_go && bank_hit[gb]),
      .pre_go_i    (pre_go && bank_hit[gb]),
      .active_o    (bank_active[gb]),
      .act_rdy_o   (bank_act_rdy[gb]),
      .col_rdy_o   (bank_col_rdy[gb]),
      .pre_rdy_o   (bank_pre_rdy[gb]),
      .force_pre_o (force_pre_o[gb])
    );
  end

endmodule

// File: rtl/sdtg_checker.sv
module sdtg_checker #(
  parameter int unsigned BANK_BITS = 2,
  parameter int unsigned T_RRD     = 2,
  parameter int unsigned T_WR      = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      issue_i,
  input logic [1:0]                cmd_i,
  input logic [BANK_BITS-1:0]      bank_i,
  input logic                      act_ok_o,
  input logic                      rd_ok_o,
  input logic                      wr_ok_o,
  input logic                      pre_ok_o,
  input logic [(1<<BANK_BITS)-1:0] force_pre_o
);

  logic act_acc;
  logic wr_acc;
  logic pre_acc;
  assign act_acc = issue_i && (cmd_i == 2'd0) && act_ok_o;
  assign wr_acc  = issue_i && (cmd_i == 2'd2) && wr_ok_o;
  assign pre_acc = issue_i && (cmd_i == 2'd3) && pre_ok_o;

  AST_NO_REACTIVATE: assert property (@(posedge clk) disable iff (!rst_n)
    act_acc |=> ((bank_i != $past(bank_i)) || !act_ok_o));  // R2

  AST_CLOSED_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    pre_acc |=> ((bank_i != $past(bank_i)) || !(rd_ok_o || wr_ok_o || pre_ok_o)));  // R2

  AST_OPEN_XOR_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok_o || wr_ok_o || pre_ok_o) |-> !act_ok_o);  // R2

  AST_FORCE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    pre_acc |=> !force_pre_o[$past(bank_i)]);  // R10

  if (T_RRD > 1) begin : g_rrd
    AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      act_acc |=> !act_ok_o);  // R4
  end

  if (T_WR > 1) begin : g_wr
    AST_WRITE_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> ((bank_i != $past(bank_i)) || !pre_ok_o));  // R8
  end

endmodule

bind sdram_timing_guard sdtg_checker #(
  .BANK_BITS (BANK_BITS),
  .T_RRD     (T_RRD),
  .T_WR      (T_WR)
) u_sdtg_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_i     (issue_i),
  .cmd_i       (cmd_i),
  .bank_i      (bank_i),
  .act_ok_o    (act_ok_o),
  .rd_ok_o     (rd_ok_o),
  .wr_ok_o     (wr_ok_o),
  .pre_ok_o    (pre_ok_o),
  .force_pre_o (force_pre_o)
);

// File: tb/sdram_timing_guard_bench.sv
module sdram_timing_guard_bench;

  localparam int T_RCD     = 3;
  localparam int T_RRD     = 2;
  localparam int T_RAS     = 6;
  localparam int T_RC      = 10;
  localparam int T_RP      = 3;
  localparam int T_WR      = 2;
  localparam int T_CDL     = 2;
  localparam int T_RAS_MAX = 40;
  localparam int MARGIN    = 5;
  localparam int NEVER     = -100000;

  localparam logic [1:0] C_ACT = 2'd0;
  localparam logic [1:0] C_RD  = 2'd1;
  localparam logic [1:0] C_WR  = 2'd2;
  localparam logic [1:0] C_PRE = 2'd3;

  logic       clk;
  logic       rst_n;
  logic       issue;
  logic [1:0] cmd;
  logic [1:0] bank;
  logic       act_ok;
  logic       rd_ok;
  logic       wr_ok;
  logic       pre_ok;
  logic [3:0] force_pre;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  sdram_timing_guard #(
    .BANK_BITS    (2),
    .T_RCD        (T_RCD),
    .T_RRD        (T_RRD),
    .T_RAS        (T_RAS),
    .T_RC         (T_RC),
    .T_RP         (T_RP),
    .T_WR         (T_WR),
    .T_CDL        (T_CDL),
    .T_RAS_MAX    (T_RAS_MAX),
    .FORCE_MARGIN (MARGIN)
  ) u_sdram_timing_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue),
    .cmd_i       (cmd),
    .bank_i      (bank),
    .act_ok_o    (act_ok),
    .rd_ok_o     (rd_ok),
    .wr_ok_o     (wr_ok),
    .pre_ok_o    (pre_ok),
    .force_pre_o (force_pre)
  );

  int n_chk;
  int n_fail;
  int now;
  int t_act [4];
  int t_pre [4];
  int t_wr  [4];
  bit open_m [4];
  int t_gact;
  int t_gwr;
  bit done;

  // reference model, from the requirements
  function automatic bit exp_act(int b);
    return !open_m[b] && (now - t_act[b] >= T_RC) && (now - t_pre[b] >= T_RP)
           && (now - t_gact >= T_RRD);
  endfunction

  function automatic bit exp_col(int b);
    return open_m[b] && (now - t_act[b] >= T_RCD) && (now - t_gwr >= T_CDL);
  endfunction

  function automatic bit exp_pre(int b);
    return open_m[b] && (now - t_act[b] >= T_RAS) && (now - t_wr[b] >= T_WR);
  endfunction

  function automatic bit exp_force(int b);
    return open_m[b] && (now - t_act[b] >= T_RAS_MAX - MARGIN);
  endfunction

  task automatic check_bit(string scen, string reqs, string name, logic got, bit exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s: actual %b expected %b (step %0d)",
               reqs, scen, name, got, exp, now);
    end
  endtask

  // One cycle: drive, check flags (R12: same-cycle, combinational), clock, update model.
  task automatic step(string scen, bit iss, logic [1:0] c, int b);
    bit legal;
    @(negedge clk);
    issue = iss;
    cmd   = c;
    bank  = 2'(b);
    #1;
    check_bit(scen, "R4 R6 R7", "act_ok", act_ok, exp_act(b));
    check_bit(scen, "R3 R9",    "rd_ok",  rd_ok,  exp_col(b));
    check_bit(scen, "R3 R9",    "wr_ok",  wr_ok,  exp_col(b));
    check_bit(scen, "R5 R8",    "pre_ok", pre_ok, exp_pre(b));
    for (int k = 0; k < 4; k++) begin
      check_bit(scen, "R10", "force_pre", force_pre[k], exp_force(k));
    end
    case (c)
      C_ACT:   legal = exp_act(b);
      C_RD:    legal = exp_col(b);
      C_WR:    legal = exp_col(b);
      default: legal = exp_pre(b);
    endcase
    @(posedge clk);
    if (iss && legal) begin   // R11: illegal issues leave the model untouched
      case (c)
        C_ACT: begin open_m[b] = 1'b1; t_act[b] = now; t_gact = now; end
        C_WR:  begin t_wr[b] = now; t_gwr = now; end
        C_PRE: begin open_m[b] = 1'b0; t_pre[b] = now; end
        default: ;
      endcase
    end
    now++;
  endtask

  task automatic idle(string scen, int n, int b);
    for (int i = 0; i < n; i++) step(scen, 1'b0, C_RD, b);
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    done   = 1'b0;
    now    = 0;
    t_gact = NEVER;
    t_gwr  = NEVER;
    for (int k = 0; k < 4; k++) begin
      t_act[k] = NEVER; t_pre[k] = NEVER; t_wr[k] = NEVER; open_m[k] = 1'b0;
    end
    issue = 1'b0;
    cmd   = C_ACT;
    bank  = 2'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state seen for every bank
    for (int b = 0; b < 4; b++) step("R1 reset", 1'b0, C_ACT, b);

    // R12: flags follow bank_i with no clock in between
    step("R3 act b0", 1'b1, C_ACT, 0);
    step("R4 act b1 too soon", 1'b1, C_ACT, 1);
    step("R12 bank switch", 1'b0, C_ACT, 1);
    step("R12 bank switch", 1'b0, C_RD, 0);
    step("R3 rd b0 at window", 1'b1, C_RD, 0);

    // R2: column and precharge to a closed bank, activate to an open one
    step("R2 rd closed b3", 1'b1, C_RD, 3);
    step("R2 pre closed b3", 1'b1, C_PRE, 3);
    step("R2 act open b0", 1'b1, C_ACT, 0);
    step("R11 after ignored", 1'b0, C_ACT, 3);

    // R9 / R8: write, then column and precharge hold-offs
    step("R9 wr b0", 1'b1, C_WR, 0);
    step("R9 rd b0 too soon", 1'b1, C_RD, 0);
    step("R8 pre b0 at window", 1'b1, C_PRE, 0);
    step("R6 act b0 too soon", 1'b1, C_ACT, 0);
    idle("R7 wait", 2, 0);
    step("R7 act b0", 1'b1, C_ACT, 0);

    // R5: precharge before minimum active time
    step("R5 pre b0 early", 1'b1, C_PRE, 0);
    idle("R5 wait", 4, 0);
    step("R5 pre b0", 1'b1, C_PRE, 0);

    // R10: leave bank 2 open past the request point, then close it
    step("R10 act b2", 1'b1, C_ACT, 2);
    idle("R10 hold", T_RAS_MAX + 3, 2);
    step("R10 pre b2", 1'b1, C_PRE, 2);
    idle("R10 after pre", 3, 2);

    // seeded random traffic
    void'($urandom(32'h5D7A_0C11));
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step("random", (r < 75), 2'($urandom_range(0, 3)), $urandom_range(0, 3));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule